// File: doc/BRIEF.md
# Cascaded Timing Marker Generator

This block sits beside a byte-oriented transmitter that opens every frame with one marker byte sent as a control character. It counts the frames the transmitter sends and works out which marker code belongs in the next marker slot. Three nested time marks are built from that count: a fine mark every 2 microseconds, a middle mark every 1 millisecond and a coarse mark every second.

The number of frames in one 2 microsecond slot is computed at elaboration. It is twice the clock frequency in MHz divided by the number of bytes per frame. Three counters are chained: frames per 2 µs slot, 2 µs slots per millisecond and milliseconds per second. When several boundaries fall on the same slot, the coarsest one is sent.

The transmitter pulses `frame_stb` in the cycle it sends the marker byte, and it sends whatever `mark_code` shows in that cycle. One cycle later the block raises a single-cycle pulse that names the kind of marker that went out. All other slots carry an idle comma code.

Top module: `timing_mark_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, all counters are zero, `mark_code` is the idle code 8'hBC and all three sent pulses are low. A reset in the middle of a run restarts the frame count from one.
- R2: A marker slot that is not a 2 µs boundary carries the idle code 8'hBC.
- R3: With F = 2*FREQ_MHZ/BYTES_PER_FRAME, the strobe whose 1-based index since reset is a multiple of F, and is not a millisecond boundary, carries the 2 µs code 8'h1C. The first such strobe is strobe number F.
- R4: A strobe whose index is a multiple of F*SLOTS_PER_MS, but not of F*SLOTS_PER_MS*MS_PER_S, carries the 1 ms code 8'h3C in place of the 2 µs code.
- R5: A strobe whose index is a multiple of F*SLOTS_PER_MS*MS_PER_S carries the 1 s code 8'h7C in place of both finer codes. The counts then start over, so the marker pattern repeats with that period.
- R6: In the cycle after a strobe, exactly one of `sent_2us`, `sent_1ms`, `sent_1s` is high if the code sent was 8'h1C, 8'h3C or 8'h7C respectively. None is high after an idle slot or in any cycle that does not follow a strobe. Each pulse lasts one cycle.
- R7: Cycles without a strobe advance nothing: `mark_code` holds its value until the cycle after the next strobe. Back-to-back strobes in consecutive cycles each count as one frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit byte clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | High in the cycle the transmitter sends a marker byte |
| mark_code | output | 8 | Control-character code for the current or next marker slot |
| sent_2us | output | 1 | One-cycle pulse after a 2 µs marker was sent |
| sent_1ms | output | 1 | One-cycle pulse after a 1 ms marker was sent |
| sent_1s | output | 1 | One-cycle pulse after a 1 s marker was sent |

## Verification
The bench builds the block with FREQ_MHZ=6, BYTES_PER_FRAME=4, SLOTS_PER_MS=4 and MS_PER_S=3. This gives 3 frames per fine slot, a millisecond mark every 12 frames and a second mark every 36 frames. With these values every level of the cascade wraps, and coincident boundaries that call for the priority rule occur several times within a hundred strobes. Strobes come back to back, with gaps and across a mid-run reset, so both the hold behaviour and the restart of the count are exercised.

// File: rtl/tmg_pkg.sv
package tmg_pkg;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_2US  = 2'd1,
        LVL_1MS  = 2'd2,
        LVL_1S   = 2'd3
    } mark_lvl_e;

    typedef struct packed {
        logic sec;
        logic msec;
        logic usec2;
    } sent_flags_t;

    localparam int        LEVELS    = 3;
    localparam logic [7:0] CODE_IDLE = 8'hBC;
    localparam logic [7:0] CODE_2US  = 8'h1C;
    localparam logic [7:0] CODE_1MS  = 8'h3C;
    localparam logic [7:0] CODE_1S   = 8'h7C;

    // Frames in one 2 us slot, clamped so a counter never has zero length.
    function automatic int frames_per_slot(input int freq_mhz, input int bytes_per_frame);
        int f;
        f = (2 * freq_mhz) / bytes_per_frame;
        return (f < 1) ? 1 : f;
    endfunction

    function automatic logic [7:0] code_of(input mark_lvl_e lvl);
        case (lvl)
            LVL_2US: return CODE_2US;
            LVL_1MS: return CODE_1MS;
            LVL_1S:  return CODE_1S;
            default: return CODE_IDLE;
        endcase
    endfunction

    function automatic sent_flags_t flags_of(input mark_lvl_e lvl);
        sent_flags_t f;
        f       = '0;
        f.usec2 = (lvl == LVL_2US);
        f.msec  = (lvl == LVL_1MS);
        f.sec   = (lvl == LVL_1S);
        return f;
    endfunction

endpackage

// File: rtl/tmg_wrap_cnt.sv
module tmg_wrap_cnt #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic at_last
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] count;

    assign at_last = (count == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (en)
            count <= at_last ? '0 : count + W'(1);
    end
endmodule

// File: rtl/tmg_prio_sel.sv
module tmg_prio_sel
    import tmg_pkg::*;
(
    input  logic [LEVELS-1:0] at_last,
    output mark_lvl_e         lvl,
    output logic [7:0]        code
);
    always_comb begin
        if (&at_last)
            lvl = LVL_1S;
        else if (at_last[0] && at_last[1])
            lvl = LVL_1MS;
        else if (at_last[0])
            lvl = LVL_2US;
        else
            lvl = LVL_NONE;
        code = code_of(lvl);
    end
endmodule

// File: rtl/tmg_sent_pulse.sv
module tmg_sent_pulse
    import tmg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        stb,
    input  mark_lvl_e   lvl,
    output sent_flags_t flags
);
    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else if (stb)
            flags <= flags_of(lvl);
        else
            flags <= '0;
    end
endmodule

// File: rtl/timing_mark_gen.sv
module timing_mark_gen
    import tmg_pkg::*;
#(
    parameter int FREQ_MHZ        = 125,
    parameter int BYTES_PER_FRAME = 10,
    parameter int SLOTS_PER_MS    = 500,
    parameter int MS_PER_S        = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_stb,
    output logic [7:0] mark_code,
    output logic       sent_2us,
    output logic       sent_1ms,
    output logic       sent_1s
);
    localparam int FRAMES_2US = frames_per_slot(FREQ_MHZ, BYTES_PER_FRAME);

    logic [LEVELS-1:0] lvl_en;
    logic [LEVELS-1:0] lvl_last;
    mark_lvl_e         cur_lvl;
    sent_flags_t       flags;

    // Each stage advances only when every finer stage is about to wrap.
    assign lvl_en[0] = frame_stb;

    genvar gi;
    generate
        for (gi = 0; gi < LEVELS; gi++) begin : g_stage
            localparam int LIM = (gi == 0) ? FRAMES_2US :
                                 (gi == 1) ? SLOTS_PER_MS : MS_PER_S;
            if (gi > 0) begin : g_chain
                assign lvl_en[gi] = lvl_en[gi-1] & lvl_last[gi-1];
            end
            tmg_wrap_cnt #(.LIMIT(LIM)) u_cnt (
                .clk     (clk),
                .rst     (rst),
                .en      (lvl_en[gi]),
                .at_last (lvl_last[gi])
            );
        end
    endgenerate

    tmg_prio_sel u_sel (
        .at_last (lvl_last),
        .lvl     (cur_lvl),
        .code    (mark_code)
    );

    tmg_sent_pulse u_pulse (
        .clk   (clk),
        .rst   (rst),
        .stb   (frame_stb),
        .lvl   (cur_lvl),
        .flags (flags)
    );

    assign sent_2us = flags.usec2;
    assign sent_1ms = flags.msec;
    assign sent_1s  = flags.sec;
endmodule

// File: rtl/tmg_checker.sv
module tmg_checker (
    input logic       clk,
    input logic       rst,
    input logic       frame_stb,
    input logic [7:0] mark_code,
    input logic       sent_2us,
    input logic       sent_1ms,
    input logic       sent_1s
);
    // R1: reset leaves idle code and quiet pulses
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (mark_code == 8'hBC) && !sent_2us && !sent_1ms && !sent_1s);

    // R2: only the four defined codes ever appear
    a_r2_code_legal: assert property (@(posedge clk) disable iff (rst)
        (mark_code == 8'hBC) || (mark_code == 8'h1C) ||
        (mark_code == 8'h3C) || (mark_code == 8'h7C));

    // R6: at most one pulse at a time
    a_r6_one_pulse: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sent_2us, sent_1ms, sent_1s}));

    // R6: a pulse needs a strobe one cycle earlier
    a_r6_pulse_after_stb: assert property (@(posedge clk) disable iff (rst)
        (sent_2us || sent_1ms || sent_1s) |-> $past(frame_stb));

    // R5, R6: a sent 1 s code is reported
    a_r5_sec_reported: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && mark_code == 8'h7C) |=> sent_1s);

    // R4, R6: a sent 1 ms code is reported
    a_r4_ms_reported: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && mark_code == 8'h3C) |=> sent_1ms);

    // R3, R6: a sent 2 us code is reported
    a_r3_us_reported: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && mark_code == 8'h1C) |=> sent_2us);

    // R7: no strobe, no change of code
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(mark_code));
endmodule

bind timing_mark_gen tmg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_stb (frame_stb),
    .mark_code (mark_code),
    .sent_2us  (sent_2us),
    .sent_1ms  (sent_1ms),
    .sent_1s   (sent_1s)
);

// File: tb/timing_mark_gen_tb.sv
module timing_mark_gen_tb;
    localparam int FREQ  = 6;
    localparam int BPF   = 4;
    localparam int SPM   = 4;
    localparam int MPS   = 3;
    localparam int F     = (2 * FREQ) / BPF;
    localparam int P_MS  = F * SPM;
    localparam int P_S   = P_MS * MPS;

    typedef struct {
        logic [7:0] code;
        logic [2:0] pulses; // {1s,1ms,2us}
        int         idx;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_stb = 1'b0;
    logic [7:0] mark_code;
    logic       sent_2us, sent_1ms, sent_1s;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   strobes  = 0;
    exp_t q[$];

    logic       pend_valid = 1'b0;
    logic [2:0] pend_p = 3'b000;
    logic       prev_stb = 1'b0;
    logic [7:0] prev_code = 8'hBC;
    logic       prev_rst = 1'b1;

    always #5 clk = ~clk;

    timing_mark_gen #(
        .FREQ_MHZ(FREQ), .BYTES_PER_FRAME(BPF),
        .SLOTS_PER_MS(SPM), .MS_PER_S(MPS)
    ) u_dut (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .mark_code(mark_code),
        .sent_2us(sent_2us), .sent_1ms(sent_1ms), .sent_1s(sent_1s)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h expected=%0h (time %0t)", tag, got, exp, $time);
        end
    endtask

    function automatic exp_t expect_for(input int idx);
        exp_t e;
        e.idx = idx;
        if (idx % P_S == 0)       begin e.code = 8'h7C; e.pulses = 3'b100; end
        else if (idx % P_MS == 0) begin e.code = 8'h3C; e.pulses = 3'b010; end
        else if (idx % F == 0)    begin e.code = 8'h1C; e.pulses = 3'b001; end
        else                      begin e.code = 8'hBC; e.pulses = 3'b000; end
        return e;
    endfunction

    function automatic string tag_of(input logic [7:0] c);
        case (c)
            8'h7C:   return "R5";
            8'h3C:   return "R4";
            8'h1C:   return "R3";
            default: return "R2";
        endcase
    endfunction

    // Monitor: compares against the scoreboard queue away from the active edge.
    always @(negedge clk) begin
        if (rst) begin
            pend_valid = 1'b0;
            prev_stb   = 1'b0;
            prev_rst   = 1'b1;
        end else begin
            if (prev_rst) begin
                check("R1 code after reset", mark_code, 8'hBC);
            end
            check("R6 sent pulses", {sent_1s, sent_1ms, sent_2us},
                  pend_valid ? pend_p : 3'b000);
            if (!prev_stb && !prev_rst)
                check("R7 code held without strobe", mark_code, prev_code);
            pend_valid = 1'b0;
            if (frame_stb) begin
                if (q.size() == 0) begin
                    check("R7 unexpected strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(tag_of(e.code), mark_code, e.code);
                    pend_p     = e.pulses;
                    pend_valid = 1'b1;
                end
            end
            prev_stb  = frame_stb;
            prev_code = mark_code;
            prev_rst  = 1'b0;
        end
    end

    // Driver: one strobe, then an optional gap.
    task automatic send_frame(input int gap);
        @(posedge clk); #2;
        strobes++;
        q.push_back(expect_for(strobes));
        frame_stb = 1'b1;
        @(posedge clk); #2;
        frame_stb = 1'b0;
        for (int g = 1; g < gap; g++) @(posedge clk);
    endtask

    // Back-to-back frames keep the strobe high across cycles.
    task automatic burst(input int count);
        for (int i = 0; i < count; i++) begin
            @(posedge clk); #2;
            strobes++;
            q.push_back(expect_for(strobes));
            frame_stb = 1'b1;
        end
        @(posedge clk); #2;
        frame_stb = 1'b0;
    endtask

    task automatic do_reset(input int cycles);
        @(posedge clk); #2;
        rst = 1'b1;
        frame_stb = 1'b0;
        for (int i = 0; i < cycles; i++) @(posedge clk);
        #2;
        q.delete();
        strobes = 0;
        rst = 1'b0;
    endtask

    initial begin
        #1;
        // R1: state held in reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 code in reset", mark_code, 8'hBC);
        check("R1 pulses in reset", {sent_1s, sent_1ms, sent_2us}, 3'b000);
        @(posedge clk); #2;
        rst = 1'b0;
        // R7: back-to-back strobes, through a full 1 s period and beyond
        burst(40);
        // R7: spaced strobes with gaps
        for (int i = 0; i < 20; i++) send_frame(2 + (i % 3));
        // R1: mid-run reset restarts the count
        for (int i = 0; i < 7; i++) send_frame(1);
        do_reset(2);
        for (int i = 0; i < 40; i++) begin
            if (i % 2 == 0) send_frame(1);
            else            send_frame(4);
        end
        repeat (4) @(posedge clk);
        check("R5 scoreboard drained", q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired got=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule